// File: doc/BRIEF.md
# Converter Sample Sequencer Result Queues

This block is the digital back end of a four-channel sample sequencer for an analog converter. Each sequencer owns a 16-deep result queue and an interrupt line. Software sets which sequencers are enabled and, for each one, a 4-bit trigger-source code. When the timer trigger input is high on a clock edge, every enabled sequencer whose code selects the timer source (code 5) appends one result word to its queue and sets its raw interrupt bit.

A result word is either a pseudo-random value (0x200 plus three bits of a linear congruential generator) or the value on the external sample port, chosen per sequencer. Software drains a queue by reading that sequencer's data register, which pops one entry. It watches progress through a packed status word that carries the read pointer, write pointer, empty and full flags. Sticky per-sequencer flags record dropped pushes and reads of an empty queue.

The register port is a simple synchronous bus. Writes take effect on the clock edge with `bus_wr` high. Read data is combinational from `bus_addr`, and a read of a data register pops on the edge where `bus_rd` is high.

Top module: `adc_seq_frontend`

## Requirements
- R1: After reset every queue status word reads 0x100 (empty bit 8 set, pointers zero), all flag registers read 0 and `irq` is 0.
- R2: The status word of sequencer n (address 0x4C + 0x20·n) holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. A push stores at the write pointer and advances it modulo 16.
- R3: Sixteen pushes with no pops set full and make both pointers equal. A further push is dropped, leaves the status word unchanged and sets bit n of the overflow register (0x10).
- R4: Reading the data register (0x48 + 0x20·n) returns the oldest entry and advances the read pointer modulo 16. Entries leave in push order, and empty sets when the read pointer reaches the write pointer.
- R5: Reading an empty queue returns 0, leaves its status word unchanged and sets bit n of the underflow register (0x18).
- R6: Sequencer n pushes on a trigger only when bit n of the enable register (0x00, 4 bits) is set and bits 4n+3:4n of the source register (0x14) equal 5.
- R7: A generated word is 0x200 + bits 18:16 of the generator state after the update state = state·314159 + 1 (mod 2^32). The state starts at 0 and advances once per pushing sequencer, in ascending sequencer order within one trigger.
- R8: When bit 0 of a sequencer's control register (0x44 + 0x20·n) is set, its pushes take `ext_sample` instead of a generated word.
- R9: `irq[n]` equals raw bit n AND mask bit n (raw 0x04, mask 0x08). Reading 0x0C returns raw AND mask. Writing 1s to 0x0C clears those raw bits.
- R10: Writes to a sequencer's mux register (0x40 + 0x20·n) are stored ANDed with 0x33333333. Enable keeps 4 bits. Raw, mask, source and priority (0x20) read back what was written. Writing 1s to 0x10 or 0x18 clears those flag bits.
- R11: A trigger sets raw bit n for every sequencer that pushes, including when that push is dropped. In the same cycle this takes precedence over a raw write or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on a data register) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| trig | input | 1 | Timer trigger, sampled on the clock edge |
| ext_sample | input | 12 | External sample word |
| irq | output | 4 | Per-sequencer interrupt |

## Verification
A wrong pointer or count shows in the status word read straight after the trigger or pop that corrupted it. A wrong stored entry shows on the next pop of that slot, which can be up to 16 pushes later. A fault in trigger gating or generator chaining shows as an extra or missing push in a neighbouring sequencer's status, or as a wrong value in the first word drained. A sweep over all enable patterns and all source codes exposes both of these within one drain.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [3:0] SRC_TIMER = 4'd5;
  localparam logic [31:0] MUX_KEEP = 32'h3333_3333;

  // register offsets within the block
  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_MASK   = 8'h08;
  localparam logic [7:0] OFS_CLEAR  = 8'h0C;
  localparam logic [7:0] OFS_OVF    = 8'h10;
  localparam logic [7:0] OFS_SRC    = 8'h14;
  localparam logic [7:0] OFS_UNF    = 8'h18;
  localparam logic [7:0] OFS_PRIO   = 8'h20;
  localparam logic [7:0] OFS_SEQ0   = 8'h40;

  // per-sequencer sub offsets
  localparam logic [4:0] SUB_MUX  = 5'h00;
  localparam logic [4:0] SUB_CTL  = 5'h04;
  localparam logic [4:0] SUB_DATA = 5'h08;
  localparam logic [4:0] SUB_STAT = 5'h0C;

  function automatic logic [31:0] lcg_step(input logic [31:0] s);
    return s * 32'd314159 + 32'd1;
  endfunction

  function automatic logic [31:0] status_pack(input logic [3:0] rptr, input logic [3:0] wptr,
                                              input logic is_empty, input logic is_full);
    logic [31:0] w;
    w = '0;
    w[3:0] = rptr;
    w[7:4] = wptr;
    w[8] = is_empty;
    w[12] = is_full;
    return w;
  endfunction
endpackage

// File: rtl/seq_fifo.sv
module seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [31:0]   status_word,
  output logic          drop,
  output logic          underrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic is_empty, is_full, do_push, do_pop;

  assign is_empty = (cnt == '0);
  assign is_full  = (cnt == CW'(DEPTH));
  assign do_push  = push && !is_full;
  assign do_pop   = pop && !is_empty;
  assign drop     = push && is_full;
  assign underrun = pop && is_empty;
  assign pop_data = is_empty ? '0 : mem[rptr];
  assign status_word = status_pack(4'(rptr), 4'(wptr), is_empty, is_full);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_drop_holds_wptr_R3: assert property (@(posedge clk) disable iff (rst)
    (push && is_full && !pop) |=> (wptr == $past(wptr)) && is_full);
  assert_pop_advances_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !is_empty) |=> (rptr == $past(rptr) + 1'b1));
  assert_underrun_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (underrun && !push) |=> (rptr == $past(rptr)) && (wptr == $past(wptr)) && is_empty);
endmodule

// File: rtl/noise_chain.sv
module noise_chain
  import adc_seq_pkg::*;
#(
  parameter int N = 4,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         fire,
  output logic [N-1:0][DW-1:0] sample
);
  logic [31:0] state;
  logic [31:0] st [N+1];
  logic [31:0] nxt [N];

  assign st[0] = state;

  for (genvar g = 0; g < N; g++) begin : g_link
    assign nxt[g] = lcg_step(st[g]);
    assign st[g+1] = fire[g] ? nxt[g] : st[g];
    assign sample[g] = DW'(32'h200 + {29'd0, nxt[g][18:16]});
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= st[N];
  end

  assert_idle_state_R7: assert property (@(posedge clk) disable iff (rst)
    (fire == '0) |=> (state == $past(state)));
endmodule

// File: rtl/adc_seq_frontend.sv
module adc_seq_frontend
  import adc_seq_pkg::*;
#(
  parameter int NSEQ = 4,
  parameter int DEPTH = 16,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          trig,
  input  logic [DW-1:0] ext_sample,
  output logic [NSEQ-1:0] irq
);
  localparam int SW = (NSEQ > 1) ? $clog2(NSEQ) : 1;
  localparam int SRCW = 4 * NSEQ;
  localparam logic [7:0] SEQ_END = 8'(64 + 32 * NSEQ);

  logic [NSEQ-1:0] enable_r, raw_r, mask_r, ovf_r, unf_r;
  logic [SRCW-1:0] src_r, prio_r;
  logic [31:0]     smux_r [NSEQ];
  logic [31:0]     sctl_r [NSEQ];

  logic            in_seq;
  logic [7:0]      seq_off;
  logic [SW-1:0]   sidx;
  logic [4:0]      sub;
  logic [NSEQ-1:0] fire, pop, drop, underrun;
  logic [NSEQ-1:0][DW-1:0] prng;
  logic [DW-1:0]   push_data [NSEQ];
  logic [DW-1:0]   pop_data [NSEQ];
  logic [31:0]     stat_word [NSEQ];

  assign in_seq  = (bus_addr >= OFS_SEQ0) && (bus_addr < SEQ_END);
  assign seq_off = bus_addr - OFS_SEQ0;
  assign sidx    = seq_off[5 +: SW];
  assign sub     = bus_addr[4:0];

  noise_chain #(.N(NSEQ), .DW(DW)) u_noise (
    .clk(clk), .rst(rst), .fire(fire), .sample(prng)
  );

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    assign fire[n] = trig && enable_r[n] && (src_r[4*n +: 4] == SRC_TIMER);
    assign pop[n]  = bus_rd && in_seq && (sidx == SW'(n)) && (sub == SUB_DATA);
    assign push_data[n] = sctl_r[n][0] ? ext_sample : prng[n];

    seq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk(clk), .rst(rst),
      .push(fire[n]), .push_data(push_data[n]),
      .pop(pop[n]), .pop_data(pop_data[n]),
      .status_word(stat_word[n]),
      .drop(drop[n]), .underrun(underrun[n])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        smux_r[n] <= '0;
        sctl_r[n] <= '0;
      end else if (bus_wr && in_seq && sidx == SW'(n)) begin
        if (sub == SUB_MUX) smux_r[n] <= bus_wdata & MUX_KEEP;
        if (sub == SUB_CTL) sctl_r[n] <= bus_wdata;
      end
    end
  end

  logic wr_raw, wr_clr, wr_ovf, wr_unf;
  assign wr_raw = bus_wr && (bus_addr == OFS_RAW);
  assign wr_clr = bus_wr && (bus_addr == OFS_CLEAR);
  assign wr_ovf = bus_wr && (bus_addr == OFS_OVF);
  assign wr_unf = bus_wr && (bus_addr == OFS_UNF);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_r <= '0;
      raw_r    <= '0;
      mask_r   <= '0;
      ovf_r    <= '0;
      unf_r    <= '0;
      src_r    <= '0;
      prio_r   <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_ENABLE) enable_r <= bus_wdata[NSEQ-1:0];
      if (bus_wr && bus_addr == OFS_MASK)   mask_r   <= bus_wdata[NSEQ-1:0];
      if (bus_wr && bus_addr == OFS_SRC)    src_r    <= bus_wdata[SRCW-1:0];
      if (bus_wr && bus_addr == OFS_PRIO)   prio_r   <= bus_wdata[SRCW-1:0];
      raw_r <= (wr_raw ? bus_wdata[NSEQ-1:0]
                       : (wr_clr ? (raw_r & ~bus_wdata[NSEQ-1:0]) : raw_r)) | fire;
      ovf_r <= (wr_ovf ? (ovf_r & ~bus_wdata[NSEQ-1:0]) : ovf_r) | drop;
      unf_r <= (wr_unf ? (unf_r & ~bus_wdata[NSEQ-1:0]) : unf_r) | underrun;
    end
  end

  assign irq = raw_r & mask_r;

  always_comb begin
    bus_rdata = '0;
    if (in_seq) begin
      for (int n = 0; n < NSEQ; n++) begin
        if (sidx == SW'(n)) begin
          case (sub)
            SUB_MUX:  bus_rdata = smux_r[n];
            SUB_CTL:  bus_rdata = sctl_r[n];
            SUB_DATA: bus_rdata = 32'(pop_data[n]);
            SUB_STAT: bus_rdata = stat_word[n];
            default:  bus_rdata = '0;
          endcase
        end
      end
    end else begin
      case (bus_addr)
        OFS_ENABLE: bus_rdata = 32'(enable_r);
        OFS_RAW:    bus_rdata = 32'(raw_r);
        OFS_MASK:   bus_rdata = 32'(mask_r);
        OFS_CLEAR:  bus_rdata = 32'(raw_r & mask_r);
        OFS_OVF:    bus_rdata = 32'(ovf_r);
        OFS_SRC:    bus_rdata = 32'(src_r);
        OFS_UNF:    bus_rdata = 32'(unf_r);
        OFS_PRIO:   bus_rdata = 32'(prio_r);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assert_fire_sets_raw_R11: assert property (@(posedge clk) disable iff (rst)
    (fire != '0) |=> ((raw_r & $past(fire)) == $past(fire)));
  assert_drop_flags_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    (drop != '0) |=> ((ovf_r & $past(drop)) == $past(drop)));
  assert_underrun_flags_unf_R5: assert property (@(posedge clk) disable iff (rst)
    (underrun != '0) |=> ((unf_r & $past(underrun)) == $past(underrun)));
endmodule

// File: tb/adc_seq_frontend_test.sv
module adc_seq_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DW = 12;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0, trig = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [DW-1:0] ext_sample = 0;
  logic [NS-1:0] irq;

  int n_checks = 0, n_fail = 0;

  // bench model
  logic [DW-1:0] mq [NS][16];
  int mh [NS], mt [NS], mc [NS];
  logic [31:0] m_noise = 0;
  logic [3:0] m_en = 0, m_raw = 0, m_ovf = 0;
  logic [15:0] m_src = 0;
  logic [3:0] m_ext = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_frontend uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig(trig),
    .ext_sample(ext_sample), .irq(irq)
  );

  function automatic logic [31:0] gen_next(input logic [31:0] s);
    logic [63:0] p;
    p = {32'd0, s} * 64'd314159 + 64'd1;
    return p[31:0];
  endfunction

  function automatic logic [31:0] exp_status(input int n);
    logic [31:0] v;
    v = 32'(mt[n] % 16) | (32'(mh[n] % 16) << 4);
    if (mc[n] == 0) v = v | 32'h100;
    if (mc[n] == 16) v = v | 32'h1000;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic fire_once();
    trig = 1;
    @(posedge clk); #1;
    trig = 0;
    for (int n = 0; n < NS; n++) begin
      if (m_en[n] && m_src[4*n +: 4] == 4'd5) begin
        logic [DW-1:0] v;
        m_noise = gen_next(m_noise);
        v = m_ext[n] ? ext_sample : DW'(12'h200 + 12'((m_noise >> 16) & 7));
        m_raw[n] = 1'b1;
        if (mc[n] == 16) m_ovf[n] = 1'b1;
        else begin
          mq[n][mh[n]] = v; mh[n] = (mh[n] + 1) % 16; mc[n]++;
        end
      end
    end
  endtask

  task automatic check_all_status(input string req);
    logic [31:0] d;
    for (int n = 0; n < NS; n++) begin
      rd(8'(8'h4C + 32 * n), d);
      check(req, d, exp_status(n));
    end
  endtask

  task automatic drain(input int n, input string req);
    logic [31:0] d;
    while (mc[n] > 0) begin
      rd(8'(8'h48 + 32 * n), d);
      check(req, d, 32'(mq[n][mt[n]]));
      mt[n] = (mt[n] + 1) % 16; mc[n]--;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NS; n++) begin mh[n] = 0; mt[n] = 0; mc[n] = 0; end
    repeat (3) @(posedge clk); #1;
    rst = 0;

    // R1 reset state
    check_all_status("R1 reset status");
    rd(8'h04, d); check("R1 raw", d, 0);
    rd(8'h10, d); check("R1 ovf", d, 0);
    rd(8'h18, d); check("R1 unf", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R10 register readback
    wr(8'h00, 32'hFF); rd(8'h00, d); check("R10 enable width", d, 32'hF);
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, d); check("R10 mux mask", d, 32'h3333_3333);
    wr(8'h14, 32'h1234); rd(8'h14, d); check("R10 source", d, 32'h1234);
    wr(8'h20, 32'hBEEF); rd(8'h20, d); check("R10 priority", d, 32'hBEEF);
    wr(8'h08, 32'hA); rd(8'h08, d); check("R10 mask", d, 32'hA);
    wr(8'h08, 0);

    // R6 enable sweep with all sources on timer
    wr(8'h14, 32'h5555); m_src = 16'h5555;
    for (int a = 0; a < 16; a++) begin
      wr(8'h00, 32'(a)); m_en = 4'(a);
      fire_once();
      check_all_status("R6 enable sweep status");
      rd(8'h04, d); check("R11 raw after trigger", d, 32'(m_raw));
    end
    // R2 R4 R7 drain in order
    for (int n = 0; n < NS; n++) drain(n, "R7 generated word order");
    check_all_status("R4 empty after drain");

    // R6 source-code sweep on sequencer 0
    wr(8'h00, 32'h1); m_en = 4'h1;
    for (int c = 0; c < 16; c++) begin
      wr(8'h14, 32'(c)); m_src = 16'(c);
      fire_once();
      check_all_status("R6 source sweep status");
    end
    drain(0, "R6 source sweep data");

    // R3 fill sequencer 2 past full
    wr(8'h00, 32'h4); m_en = 4'h4;
    wr(8'h14, 32'h0500); m_src = 16'h0500;
    for (int k = 0; k < 17; k++) begin
      fire_once();
      rd(8'h8C, d); check("R3 R2 fill status", d, exp_status(2));
    end
    rd(8'h10, d); check("R3 overflow flag", d, 32'(m_ovf));
    drain(2, "R4 pop order after full");

    // R5 pop empty
    rd(8'h88, d); check("R5 empty pop data", d, 0);
    rd(8'h8C, d); check("R5 empty status", d, exp_status(2));
    rd(8'h18, d); check("R5 underflow flag", d, 32'h4);
    wr(8'h18, 32'h4); rd(8'h18, d); check("R10 underflow clear", d, 0);
    wr(8'h10, 32'hF); m_ovf = 0; rd(8'h10, d); check("R10 overflow clear", d, 0);

    // R8 external sample
    wr(8'hA4, 32'h1); m_ext[3] = 1'b1;
    wr(8'h00, 32'h8); m_en = 4'h8;
    wr(8'h14, 32'h5000); m_src = 16'h5000;
    ext_sample = 12'h5A5;
    fire_once();
    ext_sample = 12'h0F0;
    fire_once();
    drain(3, "R8 external word");

    // R9 interrupts
    wr(8'h04, 32'hF); m_raw = 4'hF;
    wr(8'h08, 32'h5);
    check("R9 irq masked", 32'(irq), 32'h5);
    rd(8'h0C, d); check("R9 clear reg read", d, 32'h5);
    wr(8'h0C, 32'h1); m_raw = 4'hE;
    rd(8'h04, d); check("R9 raw after clear", d, 32'hE);
    check("R9 irq after clear", 32'(irq), 32'h4);
    // R11 trigger beats clear in the same cycle
    bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'hF; trig = 1;
    @(posedge clk); #1;
    bus_wr = 0; trig = 0;
    rd(8'h04, d); check("R11 trigger over clear", d, 32'h8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule